// File: doc/BRIEF.md
# Write-Completion Status Read Responder

This block sits on the read path of an electrically erasable memory model. It chooses what the 8-bit data output carries on every read. A read is in effect when the active-low chip enable and output enable are both low and the write enable is high. When no self-timed write is running, the output carries the array word. While a write is running, the output carries a status word instead, and software can watch this word to learn when the write has ended.

The status word supports two methods of detecting the end of a write:

- **Polling:** bit 7 returns the inverse of bit 7 of the last byte written.
- **Toggle:** bit 6 flips on each new read.

Bits 5 down to 0 repeat the last byte written. Polling may begin at any point in the write. The output and its enable are registered, so they follow the sampled inputs by one clock.

Top module: `writeStatusResponder`

## Requirements
- R1: After the synchronous active-low reset, dataOe is 0, dataOut is 0, and the toggle state is cleared, so the first status read after reset shows bit 6 = 1.
- R2: A read is qualified when ceN=0, oeN=0 and weN=1 are all sampled at a clock edge. After that edge, dataOe is 1. When a read is not qualified, dataOe is 0 and dataOut is 0 after the edge.
- R3: When a qualified read is sampled with busy=0, dataOut equals the arrayData sampled at the same edge.
- R4: When a qualified read is sampled with busy=1, dataOut bit 7 equals the inverse of lastByte bit 7.
- R5: When a qualified read is sampled with busy=1, dataOut bits 5..0 equal lastByte bits 5..0.
- R6: With busy=1, dataOut bit 6 inverts at the first cycle of each new read, where a new read is a qualified cycle whose previous cycle was not qualified. Bit 6 holds for the rest of that read.
- R7: A read that starts while busy=0 does not advance the toggle state. The next status read after such reads shows bit 6 as the inverse of the last status value shown.
- R8: If busy rises during a read that is already in progress, the status word appears from the next cycle. Its bit 6 equals the toggle state at that moment, and the state does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| busy | input | 1 | Self-timed write in progress |
| lastByte | input | 8 | Last byte written |
| arrayData | input | 8 | Array read data at the current address |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| dataOut | output | 8 | Registered read data |
| dataOe | output | 1 | Registered output drive enable |

## Verification
A wrong toggle phase shows up at the ports as an incorrect bit 6 in the first cycle of the next status read, one clock after the read is qualified. A wrong read-start detector shows up in two ways: bit 6 changing within a single read, or bit 6 failing to change between reads. If the polling/array selection is wrong, bits 7 and 5..0 differ from the expected word on the very next edge. The bench mixes random busy runs and read bursts with directed cases for the reset phase, for reads while idle between writes, and for busy rising mid-read.

// File: rtl/statusPkg.sv
package statusPkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic readActive;   // qualified read sampled this cycle
    logic pollMode;     // return status word instead of array word
    logic toggleShow;   // value of the toggle bit for this cycle
  } strobeT;
endpackage

// File: rtl/statusControl.sv
module statusControl
  import statusPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   busy,
  input  logic   ceN,
  input  logic   oeN,
  input  logic   weN,
  output strobeT strobes
);
  logic readQual;
  logic readPrev;
  logic readStart;
  logic toggleState;

  assign readQual  = !ceN && !oeN && weN;
  assign readStart = readQual && !readPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readPrev    <= 1'b0;
      toggleState <= 1'b0;
    end else begin
      readPrev <= readQual;
      if (readStart && busy) toggleState <= ~toggleState;
    end
  end

  always_comb begin
    strobes.readActive = readQual;
    strobes.pollMode   = busy;
    strobes.toggleShow = (readStart && busy) ? ~toggleState : toggleState;
  end

  // Within one read, or outside a write, the toggle phase does not move
  assert_toggle_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (readQual && readPrev) |=> $stable(toggleState));
  assert_idle_no_advance_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy) |=> $stable(toggleState));
  assert_new_read_flips_R6: assert property (@(posedge clk) disable iff (!rstN)
    (readQual && !readPrev && busy) |=> (toggleState != $past(toggleState)));
endmodule

// File: rtl/statusDatapath.sv
module statusDatapath
  import statusPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int POLL_IX = 7,
  parameter int TOG_IX  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  input  logic [DATA_W-1:0] lastByte,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam logic [DATA_W-1:0] PLAIN_MASK =
    ~((DATA_W'(1) << POLL_IX) | (DATA_W'(1) << TOG_IX));

  logic [DATA_W-1:0] pollWord;
  logic [DATA_W-1:0] nextWord;

  for (genvar i = 0; i < DATA_W; i++) begin : g_pollBit
    if (i == POLL_IX) begin : g_inv
      assign pollWord[i] = ~lastByte[i];
    end else if (i == TOG_IX) begin : g_tog
      assign pollWord[i] = strobes.toggleShow;
    end else begin : g_copy
      assign pollWord[i] = lastByte[i];
    end
  end

  always_comb begin
    if (!strobes.readActive)   nextWord = '0;
    else if (strobes.pollMode) nextWord = pollWord;
    else                       nextWord = arrayData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOut <= nextWord;
      dataOe  <= strobes.readActive;
    end
  end

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.readActive) |=> (!dataOe && dataOut == '0));
  assert_drive_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readActive |=> dataOe);
  assert_array_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readActive && !strobes.pollMode) |=> (dataOut == $past(arrayData)));
  assert_poll_bit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readActive && strobes.pollMode) |=> (dataOut[POLL_IX] != $past(lastByte[POLL_IX])));
  assert_poll_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.readActive && strobes.pollMode) |=>
      (((dataOut ^ $past(lastByte)) & PLAIN_MASK) == '0));
endmodule

// File: rtl/writeStatusResponder.sv
module writeStatusResponder
  import statusPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int POLL_IX = 7,
  parameter int TOG_IX  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busy,
  input  logic [DATA_W-1:0] lastByte,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  strobeT strobes;

  statusControl uCtrl (
    .clk(clk), .rstN(rstN), .busy(busy),
    .ceN(ceN), .oeN(oeN), .weN(weN), .strobes(strobes)
  );

  statusDatapath #(.DATA_W(DATA_W), .POLL_IX(POLL_IX), .TOG_IX(TOG_IX)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .lastByte(lastByte), .arrayData(arrayData),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/sim_writeStatusResponder.sv
module sim_writeStatusResponder;
  logic clk = 0, rstN = 0, busy = 0, ceN = 1, oeN = 1, weN = 1;
  logic [7:0] lastByte = 0, arrayData = 0, dataOut;
  logic dataOe;
  int nChecks = 0, nFails = 0;
  logic mTog = 0, mPrev = 0, expOe = 0;
  logic [7:0] expOut = 0;

  always #4 clk = ~clk;

  writeStatusResponder u0 (.clk(clk), .rstN(rstN), .busy(busy), .lastByte(lastByte),
    .arrayData(arrayData), .ceN(ceN), .oeN(oeN), .weN(weN), .dataOut(dataOut), .dataOe(dataOe));

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [7:0] pollWord(logic [7:0] lb, logic tg);
    return {~lb[7], tg, lb[5:0]};
  endfunction

  // Apply inputs at negedge, model the edge, check after it
  task automatic step(logic b, logic c, logic o, logic w, logic [7:0] lb, logic [7:0] ar, string ctx);
    logic act, start, show;
    busy = b; ceN = c; oeN = o; weN = w; lastByte = lb; arrayData = ar;
    act = !c && !o && w;
    start = act && !mPrev;
    show = (start && b) ? ~mTog : mTog;
    expOe = act;
    expOut = !act ? 8'h00 : (b ? pollWord(lb, show) : ar);
    if (start && b) mTog = ~mTog;
    mPrev = act;
    @(posedge clk); @(negedge clk);
    check({"R2 oe ", ctx}, {7'b0, dataOe}, {7'b0, expOe});
    if (!act) check({"R2 idle ", ctx}, dataOut, 8'h00);
    else if (!b) check({"R3 array ", ctx}, dataOut, expOut);
    else begin
      check({"R4 bit7 ", ctx}, {7'b0, dataOut[7]}, {7'b0, expOut[7]});
      check({"R5 low ", ctx}, {2'b0, dataOut[5:0]}, {2'b0, expOut[5:0]});
      check({"R6 toggle ", ctx}, {7'b0, dataOut[6]}, {7'b0, expOut[6]});
    end
  endtask

  initial begin
    #1_000_000;
    nFails++; nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk); @(negedge clk);
    check("R1 reset out", dataOut, 8'h00);
    check("R1 reset oe", {7'b0, dataOe}, 8'h00);
    rstN = 1;
    // R1: first status read after reset shows bit6=1
    step(1, 0, 0, 1, 8'hA5, 8'h3C, "R1 first");
    check("R1 first toggle", {7'b0, dataOut[6]}, 8'h01);
    step(1, 0, 0, 1, 8'hA5, 8'h3C, "R6 hold");
    step(1, 1, 0, 1, 8'hA5, 8'h3C, "R2 gap");
    step(1, 0, 0, 1, 8'h5A, 8'h3C, "R6 second");
    check("R6 second toggle", {7'b0, dataOut[6]}, 8'h00);
    step(1, 0, 0, 0, 8'h5A, 8'h3C, "R2 we low");
    step(1, 0, 1, 1, 8'h5A, 8'h3C, "R2 oe high");
    // R7: idle reads do not advance toggle
    step(0, 0, 0, 1, 8'h5A, 8'h77, "R7 idle1");
    step(0, 1, 1, 1, 8'h5A, 8'h77, "R7 gap");
    step(0, 0, 0, 1, 8'h5A, 8'h81, "R7 idle2");
    step(0, 1, 1, 1, 8'h5A, 8'h81, "R7 gap2");
    step(1, 0, 0, 1, 8'hFF, 8'h81, "R7 resume");
    check("R7 resume toggle", {7'b0, dataOut[6]}, 8'h01);
    step(1, 1, 1, 1, 8'hFF, 8'h81, "R7 end");
    // R8: busy rises during an ongoing read
    step(0, 0, 0, 1, 8'h00, 8'h42, "R8 pre");
    step(1, 0, 0, 1, 8'h00, 8'h42, "R8 rise");
    check("R8 toggle no advance", {7'b0, dataOut[6]}, 8'h01);
    step(1, 0, 0, 1, 8'h00, 8'h42, "R8 hold");
    step(0, 0, 0, 1, 8'h00, 8'h42, "R8 done");
    step(0, 1, 1, 1, 8'h00, 8'h42, "R8 end");
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      logic b;
      b = (($urandom % 16) < 9);
      step(b, ($urandom % 4) == 0, ($urandom % 5) == 0, ($urandom % 6) != 0,
           8'($urandom), 8'($urandom), "rand");
    end
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule